// File: doc/BRIEF.md
# Dual Accumulator Saturation Unit

This block sits after the 40-bit adder of a fractional DSP datapath with two accumulators, A and B. Each accumulator holds a signed 9.31 value, which is 8 guard bits above a 1.31 field. On every write cycle the unit receives the raw adder sum, the adder's bit-39 overflow indication, and a select that names the target accumulator. It then decides what value is stored in that accumulator.

A two-bit mode input selects the overflow policy. In bit-39 saturation, a sum that overflows the full 40-bit range is clamped to the nearest 40-bit extreme. In bit-31 saturation, any sum outside the 1.31 range is clamped to the nearest 1.31 extreme. In the wrap (catastrophic) policy the sum is stored as is, and a bit-39 overflow is only reported.

For each accumulator the unit keeps two flags. The overflow flag shows whether the last result for that accumulator left the 1.31 range. The sticky saturation flag records any clamp or catastrophic overflow and holds until software clears it. The unit also drives the OR of the two overflow flags, the OR of the two sticky flags, and a one-cycle trap request.

Top module: `dual_acc_sat`

## Requirements
- R1: While `rst_n` is low, both accumulators read zero and every flag output and `trap_o` read 0.
- R2: With `mode_i` = 2'b10, a write with `ovf39_i` = 1 stores 40'h7FFFFFFFFF when the true sign (`sum_i[39]` XOR `ovf39_i`) is 0, and stores 40'h8000000000 when it is 1. The write also sets the target's sticky flag. Without `ovf39_i`, the sum is stored unchanged.
- R3: In modes 2'b00, 2'b10 and 2'b11, each write sets the target's overflow flag (`oa_o` for A, `ob_o` for B) to 1 when `ovf39_i` = 1 or when `sum_i[39:31]` is neither all zeros nor all ones. Otherwise the write sets it to 0. The flag holds between writes to that accumulator.
- R4: With `mode_i` = 2'b01, a sum outside the 1.31 range (judged as in R3) is replaced by 40'h007FFFFFFF for a true-positive sum and by 40'hFF80000000 for a true-negative sum, and the target's sticky flag is set. A sum inside the range is stored unchanged. In this mode a write always leaves the target's overflow flag at 0.
- R5: With `mode_i` = 2'b00, the sum is stored unchanged, and `ovf39_i` = 1 sets the target's sticky flag. If `trap_en_i` is also 1, `trap_o` is 1 for exactly the cycle after that write. In every other case `trap_o` is 0.
- R6: A sticky flag (`sa_o`, `sb_o`) stays 1 until its own clear strobe (`clr_sa_i`, `clr_sb_i`) is seen with no set request on that flag in the same cycle.
- R7: A clear strobe without a set request drops the flag on the next cycle. A set request and a clear strobe on the same flag in the same cycle leave the flag at 1.
- R8: A write with `wr_en_i` = 1 updates only the accumulator named by `sel_b_i` (0 = A, 1 = B), and the new value appears after one clock edge. The other accumulator and its overflow flag keep their values.
- R9: `oab_o` equals `oa_o` OR `ob_o`, and `sab_o` equals `sa_o` OR `sb_o`, in every cycle.
- R10: `mode_i` = 2'b11 behaves exactly like 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write the processed sum this cycle |
| sel_b_i | input | 1 | Target accumulator: 0 = A, 1 = B |
| sum_i | input | 40 | Raw adder result |
| ovf39_i | input | 1 | Adder overflow out of bit 39 |
| mode_i | input | 2 | 00 wrap, 01 clamp at bit 31, 10/11 clamp at bit 39 |
| trap_en_i | input | 1 | Enables the catastrophic-overflow trap |
| clr_sa_i | input | 1 | Clear strobe for sticky flag A |
| clr_sb_i | input | 1 | Clear strobe for sticky flag B |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| oa_o | output | 1 | Last result of A left the 1.31 range |
| ob_o | output | 1 | Last result of B left the 1.31 range |
| sa_o | output | 1 | Sticky saturation flag of A |
| sb_o | output | 1 | Sticky saturation flag of B |
| oab_o | output | 1 | oa_o OR ob_o |
| sab_o | output | 1 | sa_o OR sb_o |
| trap_o | output | 1 | Catastrophic-overflow trap request |

## Verification
Random sums are drawn from three classes, each with a random overflow bit and mode:
- Values already inside 1.31, which show that unclamped data passes through unchanged.
- Values just across the bit-31 boundary, which separate the bit-31 clamp from the guard-bit overflow flag.
- Full-range values, which exercise bit-39 clamping and the true-sign decision when the overflow bit is set.

Directed cases cover the rest. Mode 11 is tried against mode 10. A set request and a clear strobe are driven in the same cycle. A trap is raised with the enable both set and clear. Writes go to one accumulator while the other is watched to confirm it does not move.

// File: rtl/sat_pkg.sv
package sat_pkg;
    typedef enum logic [1:0] {
        MODE_WRAP       = 2'b00,
        MODE_CLIP31     = 2'b01,
        MODE_CLIP39     = 2'b10,
        MODE_CLIP39_ALT = 2'b11
    } sat_mode_e;

    localparam int unsigned NUM_ACC = 2;
endpackage

// File: rtl/sat_classify.sv
module sat_classify
    import sat_pkg::*;
#(
    parameter int unsigned ACC_W   = 40,
    parameter int unsigned GUARD_W = 8
) (
    input  logic [ACC_W-1:0] sum_i,
    input  logic             ovf_i,
    input  sat_mode_e        mode_i,
    input  logic             trap_en_i,
    output logic [ACC_W-1:0] val_o,
    output logic             set_o,
    output logic             rng_ovf_o,
    output logic             trap_o
);
    localparam int unsigned LOW_MSB = ACC_W - GUARD_W - 1;
    localparam int unsigned TOP_W   = GUARD_W + 1;

    localparam logic [ACC_W-1:0] POS_FULL = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_FULL = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] POS_LOW  = {{TOP_W{1'b0}}, {LOW_MSB{1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LOW  = {{TOP_W{1'b1}}, {LOW_MSB{1'b0}}};

    logic [TOP_W-1:0] top_bits;
    logic             true_neg;
    logic             out_of_low;

    assign top_bits   = sum_i[ACC_W-1:LOW_MSB];
    assign true_neg   = sum_i[ACC_W-1] ^ ovf_i;
    assign out_of_low = ovf_i | ~((&top_bits) | ~(|top_bits));

    always_comb begin
        val_o     = sum_i;
        set_o     = 1'b0;
        rng_ovf_o = out_of_low;
        trap_o    = 1'b0;
        unique case (mode_i)
            MODE_WRAP: begin
                set_o  = ovf_i;
                trap_o = ovf_i & trap_en_i;
            end
            MODE_CLIP31: begin
                rng_ovf_o = 1'b0;
                if (out_of_low) begin
                    val_o = true_neg ? NEG_LOW : POS_LOW;
                    set_o = 1'b1;
                end
            end
            MODE_CLIP39, MODE_CLIP39_ALT: begin
                if (ovf_i) begin
                    val_o = true_neg ? NEG_FULL : POS_FULL;
                    set_o = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/sat_slot.sv
module sat_slot #(
    parameter int unsigned ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [ACC_W-1:0] val_i,
    input  logic             rng_ovf_i,
    input  logic             set_i,
    input  logic             clr_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             ovf_o,
    output logic             sticky_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o    <= '0;
            ovf_o    <= 1'b0;
            sticky_o <= 1'b0;
        end else begin
            if (wr_i) begin
                acc_o <= val_i;
                ovf_o <= rng_ovf_i;
            end
            if (wr_i && set_i) begin
                sticky_o <= 1'b1;
            end else if (clr_i) begin
                sticky_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_acc_sat.sv
module dual_acc_sat
    import sat_pkg::*;
#(
    parameter int unsigned ACC_W   = 40,
    parameter int unsigned GUARD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             sel_b_i,
    input  logic [ACC_W-1:0] sum_i,
    input  logic             ovf39_i,
    input  logic [1:0]       mode_i,
    input  logic             trap_en_i,
    input  logic             clr_sa_i,
    input  logic             clr_sb_i,
    output logic [ACC_W-1:0] acc_a_o,
    output logic [ACC_W-1:0] acc_b_o,
    output logic             oa_o,
    output logic             ob_o,
    output logic             sa_o,
    output logic             sb_o,
    output logic             oab_o,
    output logic             sab_o,
    output logic             trap_o
);
    logic [ACC_W-1:0]   new_val;
    logic               new_set;
    logic               new_rng;
    logic               new_trap;
    logic [NUM_ACC-1:0] wr_vec;
    logic [NUM_ACC-1:0] clr_vec;
    logic [NUM_ACC-1:0] ovf_vec;
    logic [NUM_ACC-1:0] stk_vec;
    logic [ACC_W-1:0]   acc_q [NUM_ACC];

    sat_classify #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) i_classify (
        .sum_i     (sum_i),
        .ovf_i     (ovf39_i),
        .mode_i    (sat_mode_e'(mode_i)),
        .trap_en_i (trap_en_i),
        .val_o     (new_val),
        .set_o     (new_set),
        .rng_ovf_o (new_rng),
        .trap_o    (new_trap)
    );

    assign clr_vec = {clr_sb_i, clr_sa_i};

    for (genvar k = 0; k < NUM_ACC; k++) begin : g_slot
        assign wr_vec[k] = wr_en_i && (sel_b_i == k[0]);
        sat_slot #(.ACC_W(ACC_W)) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_vec[k]),
            .val_i     (new_val),
            .rng_ovf_i (new_rng),
            .set_i     (new_set),
            .clr_i     (clr_vec[k]),
            .acc_o     (acc_q[k]),
            .ovf_o     (ovf_vec[k]),
            .sticky_o  (stk_vec[k])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trap_o <= 1'b0;
        else        trap_o <= wr_en_i & new_trap;
    end

    assign acc_a_o = acc_q[0];
    assign acc_b_o = acc_q[1];
    assign oa_o    = ovf_vec[0];
    assign ob_o    = ovf_vec[1];
    assign sa_o    = stk_vec[0];
    assign sb_o    = stk_vec[1];
    assign oab_o   = |ovf_vec;
    assign sab_o   = |stk_vec;
endmodule

// File: rtl/dual_acc_sat_chk.sv
module dual_acc_sat_chk #(
    parameter int unsigned ACC_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic             sel_b_i,
    input logic [ACC_W-1:0] sum_i,
    input logic             ovf39_i,
    input logic [1:0]       mode_i,
    input logic             trap_en_i,
    input logic             clr_sa_i,
    input logic [ACC_W-1:0] acc_a_o,
    input logic [ACC_W-1:0] acc_b_o,
    input logic             oa_o,
    input logic             sa_o,
    input logic             trap_o
);
    localparam logic [ACC_W-1:0] POS_FULL = {1'b0, {(ACC_W-1){1'b1}}};

    p_clip39_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !sel_b_i && mode_i[1] && ovf39_i && sum_i[ACC_W-1])
        |=> (acc_a_o == POS_FULL && sa_o));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !sel_b_i && mode_i == 2'b01) |=> !oa_o);

    p_trap_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> $past(wr_en_i && trap_en_i && ovf39_i && mode_i == 2'b00));

    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sa_o && !clr_sa_i) |=> sa_o);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sa_i && !(wr_en_i && !sel_b_i)) |=> !sa_o);

    p_other_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !sel_b_i) |=> $stable(acc_b_o));
endmodule

bind dual_acc_sat dual_acc_sat_chk #(.ACC_W(ACC_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .sel_b_i   (sel_b_i),
    .sum_i     (sum_i),
    .ovf39_i   (ovf39_i),
    .mode_i    (mode_i),
    .trap_en_i (trap_en_i),
    .clr_sa_i  (clr_sa_i),
    .acc_a_o   (acc_a_o),
    .acc_b_o   (acc_b_o),
    .oa_o      (oa_o),
    .sa_o      (sa_o),
    .trap_o    (trap_o)
);

// File: tb/test_dual_acc_sat.sv
module test_dual_acc_sat;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0, sel_b_i = 1'b0, ovf39_i = 1'b0;
    logic [39:0] sum_i = '0;
    logic [1:0]  mode_i = 2'b00;
    logic        trap_en_i = 1'b0, clr_sa_i = 1'b0, clr_sb_i = 1'b0;
    logic [39:0] acc_a_o, acc_b_o;
    logic        oa_o, ob_o, sa_o, sb_o, oab_o, sab_o, trap_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [39:0] e_acc [2];
    logic        e_of [2];
    logic        e_s [2];
    logic        e_trap;

    always #10 clk = ~clk;

    dual_acc_sat i_dual_acc_sat (.*);

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [39:0] s, input logic v, input logic [1:0] m,
                                  input logic ten, output logic [39:0] val, output logic setf,
                                  output logic of, output logic tr);
        logic guard, neg;
        guard = v | !(s[39:31] == 9'h1FF || s[39:31] == 9'h000);
        neg   = s[39] ^ v;
        val = s; setf = 0; of = guard; tr = 0;
        case (m)
            2'b00: begin setf = v; tr = v & ten; end
            2'b01: begin
                of = 0;
                if (guard) begin val = neg ? 40'hFF80000000 : 40'h007FFFFFFF; setf = 1; end
            end
            default: if (v) begin val = neg ? 40'h8000000000 : 40'h7FFFFFFFFF; setf = 1; end
        endcase
    endfunction

    task automatic step(input logic wr, input logic sb, input logic [39:0] s, input logic v,
                        input logic [1:0] m, input logic ten, input logic ca, input logic cb);
        logic [39:0] val; logic setf, of, tr;
        string tag;
        wr_en_i = wr; sel_b_i = sb; sum_i = s; ovf39_i = v; mode_i = m;
        trap_en_i = ten; clr_sa_i = ca; clr_sb_i = cb;
        model(s, v, m, ten, val, setf, of, tr);
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            logic hit, clr;
            hit = wr && (sb == k[0]);
            clr = (k == 0) ? ca : cb;
            if (hit) begin e_acc[k] = val; e_of[k] = of; end
            if (hit && setf) e_s[k] = 1'b1;
            else if (clr)    e_s[k] = 1'b0;
        end
        e_trap = wr & tr;
        @(negedge clk);
        tag = (m == 2'b01) ? "R4" : (m == 2'b00) ? "R5" : "R2";
        chk(sb ? "R8 acc_a" : {tag, " acc_a"}, acc_a_o, e_acc[0]);
        chk(sb ? {tag, " acc_b"} : "R8 acc_b", acc_b_o, e_acc[1]);
        chk("R3 oa", {39'b0, oa_o}, {39'b0, e_of[0]});
        chk("R3 ob", {39'b0, ob_o}, {39'b0, e_of[1]});
        chk("R6 sa", {39'b0, sa_o}, {39'b0, e_s[0]});
        chk("R6 sb", {39'b0, sb_o}, {39'b0, e_s[1]});
        chk("R9 oab", {39'b0, oab_o}, {39'b0, e_of[0] | e_of[1]});
        chk("R9 sab", {39'b0, sab_o}, {39'b0, e_s[0] | e_s[1]});
        chk("R5 trap", {39'b0, trap_o}, {39'b0, e_trap});
    endtask

    initial begin
        process::self().srandom(32'd4242);
        for (int k = 0; k < 2; k++) begin e_acc[k] = '0; e_of[k] = 0; e_s[k] = 0; end
        e_trap = 0;
        repeat (3) @(negedge clk);
        chk("R1 acc_a", acc_a_o, 40'h0);
        chk("R1 acc_b", acc_b_o, 40'h0);
        chk("R1 flags", {33'b0, oa_o, ob_o, sa_o, sb_o, oab_o, sab_o, trap_o}, 40'h0);
        rst_n = 1'b1;

        // R2 clamp both directions on A
        step(1, 0, 40'h8000000005, 1, 2'b10, 0, 0, 0);
        chk("R2 pos clamp", acc_a_o, 40'h7FFFFFFFFF);
        step(1, 0, 40'h7FFFFFFFF0, 1, 2'b10, 0, 1, 0);
        chk("R7 set wins", {39'b0, sa_o}, 40'h1);
        chk("R2 neg clamp", acc_a_o, 40'h8000000000);
        step(0, 0, 40'h0, 0, 2'b00, 0, 1, 0);
        chk("R7 clear", {39'b0, sa_o}, 40'h0);
        // R10 mode 11 equals mode 10
        step(1, 1, 40'h8000000000, 1, 2'b11, 0, 0, 0);
        chk("R10 alt mode", acc_b_o, 40'h7FFFFFFFFF);
        // R4 bit-31 limits
        step(1, 1, 40'h0080000000, 0, 2'b01, 0, 0, 1);
        chk("R4 pos31", acc_b_o, 40'h007FFFFFFF);
        step(1, 1, 40'hFF7FFFFFFF, 0, 2'b01, 0, 0, 0);
        chk("R4 neg31", acc_b_o, 40'hFF80000000);
        chk("R4 ob low", {39'b0, ob_o}, 40'h0);
        // R5 trap enable/disable
        step(1, 0, 40'h8000000001, 1, 2'b00, 0, 0, 0);
        chk("R5 no trap", {39'b0, trap_o}, 40'h0);
        step(1, 0, 40'h8000000001, 1, 2'b00, 1, 0, 0);
        chk("R5 trap", {39'b0, trap_o}, 40'h1);
        chk("R5 wrap", acc_a_o, 40'h8000000001);

        for (int i = 0; i < 3000; i++) begin
            logic [39:0] s;
            int cls;
            cls = $urandom_range(0, 2);
            if (cls == 0)      s = {{9{$urandom_range(0,1) == 1}}, 31'($urandom)};
            else if (cls == 1) s = {{8{$urandom_range(0,1) == 1}}, 32'($urandom)};
            else               s = {8'($urandom), 32'($urandom)};
            step($urandom_range(0, 3) != 0, 1'($urandom), s, $urandom_range(0, 3) == 0,
                 2'($urandom), 1'($urandom), $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule